// File: doc/BRIEF.md
# Two-Stage Synchronizable Clock Divider

This block produces an auxiliary clock from a fast input clock using two dividers in series. The first stage is a prescaler that divides by 1, 2 or 4. The second stage is an integer divider with a 10-bit ratio from 2 to 1023, and a ratio of 0 or 1 bypasses it. The total division is the product of the two ratios, up to 4092 input cycles per output period. When the main ratio is odd, the high phase is one prescaler period shorter than the low phase.

A one-cycle synchronization strobe clears both stages together and loads the present configuration. Several copies that receive the same strobe therefore produce edges in the same input cycles. A 2-bit frequency-band code tells the block how fast the input clock runs, and the block forbids any prescaler choice that would let the main divider run too fast. If the choice is illegal, the block raises an error flag and uses divide-by-4 instead. A configuration change made between strobes takes effect only when the current output period ends.

Top module: `aux_clk_div`

## Requirements
- R1: The prescaler select codes are 0 for divide-by-1, 1 for divide-by-2 and 2 for divide-by-4. Code 3 is reserved and is always illegal.
- R2: Band code 0 allows every prescaler ratio, band code 1 allows only 2 or 4, and band codes 2 and 3 allow only 4. An illegal pair drives `cfg_err_o` high in the same cycle, combinationally from the inputs. A configuration loaded while it is illegal runs with a prescaler ratio of 4.
- R3: With a main ratio N from 2 to 1023 and a prescaler ratio P, `clk_o` repeats every P*N input cycles.
- R4: Within each period, `clk_o` is high for P*floor(N/2) input cycles and then low for the rest of the period. For odd N this gives a shorter high phase.
- R5: A main ratio of 0 or 1 bypasses the main divider. With P of 2 or 4, `clk_o` is then high for P/2 cycles and low for P/2 cycles.
- R6: When the bypass is combined with P = 1, `clk_o` follows `clk_i` directly.
- R7: The rising clock edge that samples `sync_i` high is edge 0. It clears both stages and loads the configuration inputs, and `clk_o` is low after edge 0. After edge 1+j, `clk_o` equals phase position j of the new pattern, so the first rising output edge follows edge 1.
- R8: A change of ratio, select or band between strobes does not alter the period in progress. The change is loaded at the edge that ends that period.
- R9: While `rst_ni` is low, `clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_sel_i | input | 2 | Prescaler select: 0 gives /1, 1 gives /2, 2 gives /4, 3 is reserved |
| band_i | input | 2 | Input frequency band: 0 is up to 3.2 GHz, 1 is up to 6.4 GHz, 2 and 3 are above 6.4 GHz |
| ratio_i | input | 10 | Main divider ratio; 0 or 1 means bypass |
| sync_i | input | 1 | Synchronization strobe, one cycle wide |
| clk_o | output | 1 | Divided auxiliary clock |
| cfg_err_o | output | 1 | High while the prescaler and band inputs form an illegal pair |

## Verification
The main function is tried in several ways:
- Directed even and odd main ratios with each prescaler ratio separate period length from duty asymmetry.
- The largest total ratio (4 x 1023) checks that the counters wrap at full width.
- Bypass with prescalers 2 and 4 checks the bypass path, and bypass with prescaler 1 checks that the output follows the input clock.
- Random select, band and ratio triples, with each strobe checked over two periods, mix legal and illegal pairs. They tell apart a correct fallback to divide-by-4 from one that keeps the requested ratio.
- A ratio change made partway through a period shows whether the load waits for the period to end.

// File: rtl/auxdiv_pkg.sv
package auxdiv_pkg;

    typedef enum logic [1:0] {
        PRE_BY1  = 2'd0,
        PRE_BY2  = 2'd1,
        PRE_BY4  = 2'd2,
        PRE_RSVD = 2'd3
    } pre_sel_e;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_HIGH = 2'd2,
        BAND_TOP  = 2'd3
    } band_e;

    // Last count value of the prescaler for a given select
    function automatic logic [1:0] pre_last(input pre_sel_e sel);
        case (sel)
            PRE_BY1: pre_last = 2'd0;
            PRE_BY2: pre_last = 2'd1;
            default: pre_last = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/auxdiv_cfg_check.sv
module auxdiv_cfg_check
    import auxdiv_pkg::*;
(
    input  pre_sel_e sel_i,
    input  band_e    band_i,
    output logic     err_o,
    output pre_sel_e eff_sel_o
);

    logic legal;

    always_comb begin
        case (band_i)
            BAND_LOW: legal = (sel_i != PRE_RSVD);
            BAND_MID: legal = (sel_i == PRE_BY2) || (sel_i == PRE_BY4);
            default:  legal = (sel_i == PRE_BY4);
        endcase
        err_o     = !legal;
        eff_sel_o = legal ? sel_i : PRE_BY4;
    end

endmodule

// File: rtl/auxdiv_prescaler.sv
module auxdiv_prescaler
    import auxdiv_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     clear_i,
    input  pre_sel_e sel_i,
    output logic     tick_o,
    output logic     level_o
);

    typedef struct packed {
        logic [1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [1:0] last;

    always_comb begin
        last    = pre_last(sel_i);
        tick_o  = (st_q.cnt == last);
        case (sel_i)
            PRE_BY1: level_o = 1'b0;
            PRE_BY2: level_o = (st_q.cnt == 2'd0);
            default: level_o = (st_q.cnt < 2'd2);
        endcase
        st_d = st_q;
        if (clear_i || tick_o) begin
            st_d.cnt = 2'd0;
        end else begin
            st_d.cnt = st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    pre_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= pre_last(sel_i))
        else $error("prescaler count beyond selected ratio");

endmodule

// File: rtl/auxdiv_main.sv
module auxdiv_main #(
    parameter int unsigned RATIO_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [RATIO_W-1:0] n_eff_i,
    input  logic [RATIO_W-1:0] half_i,
    output logic               period_end_o,
    output logic               level_o
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } main_state_t;

    main_state_t st_d, st_q;
    logic        at_last;

    always_comb begin
        at_last      = (st_q.cnt == n_eff_i - ONE);
        period_end_o = tick_i && at_last;
        level_o      = (st_q.cnt < half_i);
        st_d         = st_q;
        if (clear_i || period_end_o) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    main_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < n_eff_i)
        else $error("main divider count beyond ratio");

endmodule

// File: rtl/aux_clk_div.sv
module aux_clk_div
    import auxdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         pre_sel_i,
    input  logic [1:0]         band_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               sync_i,
    output logic               clk_o,
    output logic               cfg_err_o
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    typedef struct packed {
        pre_sel_e           sel;
        logic [RATIO_W-1:0] n;
        logic               div;
    } top_state_t;

    top_state_t         st_d, st_q;
    pre_sel_e           eff_sel;
    logic               err;
    logic               bypass;
    logic               pass_through;
    logic [RATIO_W-1:0] n_eff;
    logic [RATIO_W-1:0] half;
    logic               pre_tick, pre_level;
    logic               period_end, main_level;
    logic               cur_level;

    auxdiv_cfg_check u_cfg (
        .sel_i     (pre_sel_e'(pre_sel_i)),
        .band_i    (band_e'(band_i)),
        .err_o     (err),
        .eff_sel_o (eff_sel)
    );

    auxdiv_prescaler u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (sync_i),
        .sel_i   (st_q.sel),
        .tick_o  (pre_tick),
        .level_o (pre_level)
    );

    auxdiv_main #(.RATIO_W(RATIO_W)) u_main (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clear_i      (sync_i),
        .tick_i       (pre_tick),
        .n_eff_i      (n_eff),
        .half_i       (half),
        .period_end_o (period_end),
        .level_o      (main_level)
    );

    always_comb begin
        bypass       = (st_q.n <= ONE);
        n_eff        = bypass ? ONE : st_q.n;
        half         = st_q.n >> 1;
        pass_through = bypass && (st_q.sel == PRE_BY1);
        cur_level    = bypass ? pre_level : main_level;

        st_d = st_q;
        if (sync_i || period_end) begin
            st_d.sel = eff_sel;
            st_d.n   = ratio_i;
        end
        st_d.div = sync_i ? 1'b0 : cur_level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sel <= PRE_BY4;
            st_q.n   <= ONE;
            st_q.div <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o     = pass_through ? clk_i : st_q.div;
    assign cfg_err_o = err;

    // R7
    sync_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> !st_q.div)
        else $error("output not low after strobe");

    // R7
    sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i ##1 (!sync_i && !pass_through)) |=> st_q.div)
        else $error("output not high one cycle after strobe");

    // R2
    err_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && cfg_err_o) |=> (st_q.sel == PRE_BY4))
        else $error("illegal select not forced to divide-by-4");

    // R8
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_i && !period_end) |=> ($stable(st_q.n) && $stable(st_q.sel)))
        else $error("configuration changed inside a period");

endmodule

// File: tb/aux_clk_div_bench.sv
module aux_clk_div_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [1:0] band = 2'd0;
    logic [9:0] ratio = 10'd2;
    logic       sync = 1'b0;
    logic       clk_out;
    logic       cfg_err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    aux_clk_div u_aux_clk_div (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pre_sel_i (pre_sel),
        .band_i    (band),
        .ratio_i   (ratio),
        .sync_i    (sync),
        .clk_o     (clk_out),
        .cfg_err_o (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit legal(input int s, input int b);
        if (b == 0) return s != 3;
        if (b == 1) return (s == 1) || (s == 2);
        return s == 2;
    endfunction

    function automatic int eff_p(input int s, input int b);
        if (!legal(s, b)) return 4;
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic int period_of(input int p, input int n);
        return (n <= 1) ? p : p * n;
    endfunction

    function automatic bit lvl(input int j, input int p, input int n);
        if (n <= 1) return (j % p) < (p / 2);
        return ((j / p) % n) < (n / 2);
    endfunction

    function automatic string tag_of(input int p, input int n);
        if (n <= 1) return "R5";
        if (n % 2 == 1) return "R4";
        if (p != 1) return "R1";
        return "R3";
    endfunction

    // Strobe with a configuration; leaves time at the negedge after edge 0
    task automatic do_sync(input int s, input int b, input int n);
        @(negedge clk);
        pre_sel = 2'(s);
        band = 2'(b);
        ratio = 10'(n);
        sync = 1'b1;
        #1;
        chk(cfg_err == !legal(s, b), "R2", int'(cfg_err), int'(!legal(s, b)));
        @(posedge clk);
        @(negedge clk);
        chk(clk_out == 1'b0, "R7", int'(clk_out), 0);
        sync = 1'b0;
    endtask

    // Check output positions j0..j1-1 after the strobe
    task automatic run_chk(input int p, input int n, input int j0, input int j1, input string req);
        for (int j = j0; j < j1; j++) begin
            @(posedge clk);
            if (p == 1 && n <= 1) begin
                #5;
                chk(clk_out == 1'b1, "R6", int'(clk_out), 1);
                @(negedge clk);
                chk(clk_out == 1'b0, "R6", int'(clk_out), 0);
            end else begin
                @(negedge clk);
                chk(clk_out == lvl(j, p, n), req, int'(clk_out), int'(lvl(j, p, n)));
            end
        end
    endtask

    task automatic case_run(input int s, input int b, input int n, input int periods);
        int p;
        p = eff_p(s, b);
        do_sync(s, b, n);
        run_chk(p, n, 0, periods * period_of(p, n), legal(s, b) ? tag_of(p, n) : "R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s, b, n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b0, "R9", int'(clk_out), 0);
        rst_n = 1'b1;

        case_run(0, 0, 2, 3);     // R3 smallest even
        case_run(0, 0, 3, 3);     // R4 odd duty
        case_run(1, 0, 7, 2);     // R1 /2 with odd
        case_run(2, 0, 10, 2);    // R1 /4
        case_run(1, 0, 0, 4);     // R5 bypass /2
        case_run(2, 1, 1, 4);     // R5 bypass /4
        case_run(0, 0, 1, 6);     // R6 pass-through
        case_run(0, 1, 5, 2);     // R2 illegal in band 1 -> /4
        case_run(3, 0, 4, 2);     // R2 reserved code
        case_run(1, 2, 6, 2);     // R2 band 2 forbids /2
        case_run(2, 0, 1023, 1);  // R3 largest total ratio

        // R8: ratio changed during the first period of ratio 6
        do_sync(0, 0, 6);
        run_chk(1, 6, 0, 2, "R8");
        ratio = 10'd3;
        pre_sel = 2'd1;
        for (int j = 2; j < 6 + 6; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j < 6)
                chk(clk_out == lvl(j, 1, 6), "R8", int'(clk_out), int'(lvl(j, 1, 6)));
            else
                chk(clk_out == lvl(j - 6, 2, 3), "R8", int'(clk_out), int'(lvl(j - 6, 2, 3)));
        end

        // Random configurations
        for (int k = 0; k < 40; k++) begin
            s = int'($urandom % 4);
            b = int'($urandom % 4);
            n = int'($urandom % 41);
            case_run(s, b, n, 2);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule